// File: doc/BRIEF.md
# OTP Serial Command Sequencer

This block is a memory-mapped controller that replays a short list of command words to the serial programming port of a one-time-programmable memory macro. Software fills a small buffer with command words, sets the device address and the number of command pairs to send, then raises an enable bit. The sequencer shifts each pair out as one serial frame and raises a completion flag in an interrupt status register. Software clears that flag by writing a one to it.

All control writes are masked. The upper half-word of the write data holds a per-bit write enable for the lower half-word. A typical use sends a single pair. The first word is a write-register byte, 0xFA (opcode 0xC0 merged with register index 0x3A). The second word is 0x09, which turns error correction off, or 0x00, which turns it on.

The state machine has four states. ST_IDLE waits for the enable bit. It moves to ST_SHIFT and loads the first frame, or it moves straight to ST_FIN when the effective count is zero. ST_SHIFT clocks the 24 frame bits out and then moves to ST_GAP. ST_GAP holds the select high for one bit period. It then moves to ST_SHIFT with the next pair loaded, or to ST_FIN after the last pair. ST_FIN sets the done flag, clears the enable bit and returns to ST_IDLE.

Top module: `otp_seq`

## Requirements
- R1: A write to the control register (byte offset 0x20) or to the count register (0x24) changes low bit k only when bit k+16 of the same write is 1. All other low bits keep their value.
- R2: The register map reads back as follows. Control at 0x20 holds the enable in bit 0 and the device address in bits 15:8. Count at 0x24 holds a 3-bit pair count in bits 2:0. Status at 0x2C holds busy in bit 0. Interrupt status at 0x304 holds done in bit 1. Buffer word n sits at 0x1000+4n, with n from 0 to 7. Unimplemented bits read 0.
- R3: For pair k, ser_csn is low for one frame of 24 bits, sent MSB first. The frame is the device address, then bits 7:0 of buffer word 2k, then bits 7:0 of buffer word 2k+1. ser_clk has a period of 4 clock cycles and is low in the first half of each bit. ser_dout does not change while ser_clk is high.
- R4: A count of N sends min(N,4) frames, and a count of 0 sends none. Between two frames, ser_csn stays high for exactly 4 cycles. ser_csn is low only while the enable bit is set.
- R5: Let the enable write land on clock edge t0 with an effective count of N. The done flag becomes 1 on edge t0+100N+2. On that same edge the enable bit clears itself. Status busy reads 1 from the enable write until that edge.
- R6: Writing 1 to bit 1 of the interrupt status register clears done, and writing 0 leaves it unchanged. If software clears done on the same edge that the sequencer sets it, done stays 1.
- R7: While the enable bit is set, writes to the control register, the count register and the buffer are ignored.
- R8: After reset, all registers read 0, ser_csn is 1, and ser_clk and ser_dout are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 13 | Byte address of the register access |
| bus_wdata | input | 32 | Write data, with the write mask in bits 31:16 for control registers |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| ser_clk | output | 1 | Serial clock to the memory macro |
| ser_csn | output | 1 | Active-low frame select |
| ser_dout | output | 1 | Serial data, MSB first |

## Verification
Two functions can act on the same clock edge. One is the sequencer's ST_FIN state setting the done flag. The other is a software write-one-to-clear of that flag. The bench derives the exact finishing edge from the count, 100 cycles per pair plus 2, and drives the clearing write onto that edge. It then expects done to read 1, and it expects done to read 0 one cycle earlier. A second overlap pits software writes to the control, count and buffer registers against a running sequence. These writes are issued mid-frame and must leave the captured frames and the read-back values unchanged.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_GAP,
        ST_FIN
    } seq_state_t;

    localparam logic [12:0] OFS_CTRL   = 13'h0020;
    localparam logic [12:0] OFS_COUNT  = 13'h0024;
    localparam logic [12:0] OFS_STATUS = 13'h002C;
    localparam logic [12:0] OFS_IRQ    = 13'h0304;
    localparam logic [12:0] OFS_BUF    = 13'h1000;

    localparam int FRAME_BITS = 24;

endpackage

// File: rtl/otp_seq_regs.sv
module otp_seq_regs
    import otp_seq_pkg::*;
#(
    parameter int BUF_WORDS = 8,
    parameter int PAIR_W    = 2,
    parameter int CNT_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [12:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              done_pulse,
    input  logic [PAIR_W-1:0] pair_idx,
    output logic              start_en,
    output logic [7:0]        dev_addr,
    output logic [CNT_W-1:0]  pair_cnt,
    output logic [7:0]        byte_a,
    output logic [7:0]        byte_b
);
    localparam int IDX_W = PAIR_W + 1;
    localparam logic [12:0] BUF_END = OFS_BUF + 13'(4 * BUF_WORDS);

    logic [BUF_WORDS-1:0][31:0] buf_q;
    logic                       en_q;
    logic                       irq_q;
    logic [7:0]                 dev_q;
    logic [CNT_W-1:0]           cnt_q;
    logic                       hit_ctrl, hit_cnt, hit_stat, hit_irq, hit_buf;
    logic                       wr_ok;
    logic [IDX_W-1:0]           widx;

    assign hit_ctrl = (bus_addr == OFS_CTRL);
    assign hit_cnt  = (bus_addr == OFS_COUNT);
    assign hit_stat = (bus_addr == OFS_STATUS);
    assign hit_irq  = (bus_addr == OFS_IRQ);
    assign hit_buf  = (bus_addr >= OFS_BUF) && (bus_addr < BUF_END);
    assign widx     = bus_addr[IDX_W+1:2];
    assign wr_ok    = bus_wr && !en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            irq_q <= 1'b0;
            dev_q <= '0;
            cnt_q <= '0;
            buf_q <= '0;
        end else begin
            if (done_pulse) begin
                en_q <= 1'b0;
            end else if (wr_ok && hit_ctrl && bus_wdata[16]) begin
                en_q <= bus_wdata[0];
            end
            if (wr_ok && hit_ctrl) begin
                dev_q <= (dev_q & ~bus_wdata[31:24]) | (bus_wdata[15:8] & bus_wdata[31:24]);
            end
            if (wr_ok && hit_cnt) begin
                cnt_q <= (cnt_q & ~bus_wdata[16 +: CNT_W])
                       | (bus_wdata[CNT_W-1:0] & bus_wdata[16 +: CNT_W]);
            end
            if (wr_ok && hit_buf) begin
                buf_q[widx] <= bus_wdata;
            end
            if (done_pulse) begin
                irq_q <= 1'b1;
            end else if (bus_wr && hit_irq && bus_wdata[1]) begin
                irq_q <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl) begin
            bus_rdata = {16'h0, dev_q, 7'h0, en_q};
        end else if (hit_cnt) begin
            bus_rdata[CNT_W-1:0] = cnt_q;
        end else if (hit_stat) begin
            bus_rdata[0] = en_q;
        end else if (hit_irq) begin
            bus_rdata[1] = irq_q;
        end else if (hit_buf) begin
            bus_rdata = buf_q[widx];
        end
    end

    assign start_en = en_q;
    assign dev_addr = dev_q;
    assign pair_cnt = cnt_q;
    assign byte_a   = buf_q[{pair_idx, 1'b0}][7:0];
    assign byte_b   = buf_q[{pair_idx, 1'b1}][7:0];

    // R1: an unmasked enable bit cannot start the sequencer
    p_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_ctrl && !bus_wdata[16] && !en_q) |=> !en_q);

    // R5: the finishing state drops the enable bit
    p_en_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !en_q);

    // R6: setting done beats a simultaneous clear
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> irq_q);

    // R7: the buffer is frozen while a sequence is pending or running
    p_buf_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> $stable(buf_q));

endmodule

// File: rtl/otp_seq_shifter.sv
module otp_seq_shifter
    import otp_seq_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int PAIRS   = 4,
    parameter int PAIR_W  = 2,
    parameter int CNT_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_en,
    input  logic [7:0]        dev_addr,
    input  logic [CNT_W-1:0]  pair_cnt,
    input  logic [7:0]        byte_a,
    input  logic [7:0]        byte_b,
    output logic [PAIR_W-1:0] pair_idx,
    output logic              done_pulse,
    output logic              ser_clk,
    output logic              ser_csn,
    output logic              ser_dout
);
    localparam int PH_W  = $clog2(CLK_DIV);
    localparam int HALF  = CLK_DIV / 2;
    localparam int BIT_W = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] PAIRS_C = CNT_W'(PAIRS);

    seq_state_t            state_q, state_d;
    logic [PH_W-1:0]       phase_q;
    logic [BIT_W-1:0]      bit_q;
    logic [CNT_W-1:0]      sent_q;
    logic [FRAME_BITS-1:0] sr_q;
    logic [CNT_W-1:0]      eff;
    logic                  ph_last;
    logic                  load;

    assign eff      = (pair_cnt > PAIRS_C) ? PAIRS_C : pair_cnt;
    assign ph_last  = (phase_q == PH_W'(CLK_DIV - 1));
    assign load     = (state_d == ST_SHIFT) && (state_q != ST_SHIFT);
    assign pair_idx = sent_q[PAIR_W-1:0];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_en) state_d = (eff == '0) ? ST_FIN : ST_SHIFT;
            ST_SHIFT: if (ph_last && bit_q == '0) state_d = ST_GAP;
            ST_GAP:   if (ph_last) state_d = (sent_q == eff) ? ST_FIN : ST_SHIFT;
            ST_FIN:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= '0;
            bit_q   <= '0;
            sent_q  <= '0;
            sr_q    <= '0;
        end else begin
            state_q <= state_d;
            if ((state_q == ST_SHIFT || state_q == ST_GAP) && !ph_last) begin
                phase_q <= phase_q + 1'b1;
            end else begin
                phase_q <= '0;
            end
            if (load) begin
                bit_q <= BIT_W'(FRAME_BITS - 1);
                sr_q  <= {dev_addr, byte_a, byte_b};
            end else if (state_q == ST_SHIFT && ph_last && bit_q != '0) begin
                bit_q <= bit_q - 1'b1;
                sr_q  <= {sr_q[FRAME_BITS-2:0], 1'b0};
            end
            if (state_q == ST_FIN) begin
                sent_q <= '0;
            end else if (state_q == ST_SHIFT && state_d == ST_GAP) begin
                sent_q <= sent_q + 1'b1;
            end
        end
    end

    always_comb begin
        ser_csn    = (state_q != ST_SHIFT);
        ser_clk    = (state_q == ST_SHIFT) && (phase_q >= PH_W'(HALF));
        ser_dout   = (state_q == ST_SHIFT) && sr_q[FRAME_BITS-1];
        done_pulse = (state_q == ST_FIN);
    end

    // R3: data holds while the serial clock is high
    p_dout_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> $stable(ser_dout));

    // R4: a frame is only open while software's enable is set
    p_csn_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_csn |-> start_en);

endmodule

// File: rtl/otp_seq.sv
module otp_seq #(
    parameter int BUF_WORDS = 8,
    parameter int CLK_DIV   = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [12:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        ser_clk,
    output logic        ser_csn,
    output logic        ser_dout
);
    localparam int PAIRS  = BUF_WORDS / 2;
    localparam int PAIR_W = $clog2(PAIRS);
    localparam int CNT_W  = PAIR_W + 1;

    logic              start_en;
    logic              done_pulse;
    logic [7:0]        dev_addr;
    logic [CNT_W-1:0]  pair_cnt;
    logic [7:0]        byte_a, byte_b;
    logic [PAIR_W-1:0] pair_idx;

    otp_seq_regs #(
        .BUF_WORDS(BUF_WORDS),
        .PAIR_W   (PAIR_W),
        .CNT_W    (CNT_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .done_pulse(done_pulse),
        .pair_idx  (pair_idx),
        .start_en  (start_en),
        .dev_addr  (dev_addr),
        .pair_cnt  (pair_cnt),
        .byte_a    (byte_a),
        .byte_b    (byte_b)
    );

    otp_seq_shifter #(
        .CLK_DIV(CLK_DIV),
        .PAIRS  (PAIRS),
        .PAIR_W (PAIR_W),
        .CNT_W  (CNT_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_en  (start_en),
        .dev_addr  (dev_addr),
        .pair_cnt  (pair_cnt),
        .byte_a    (byte_a),
        .byte_b    (byte_b),
        .pair_idx  (pair_idx),
        .done_pulse(done_pulse),
        .ser_clk   (ser_clk),
        .ser_csn   (ser_csn),
        .ser_dout  (ser_dout)
    );

endmodule

// File: tb/otp_seq_bench.sv
module otp_seq_bench;
    localparam logic [12:0] A_CTRL = 13'h0020;
    localparam logic [12:0] A_CNT  = 13'h0024;
    localparam logic [12:0] A_STAT = 13'h002C;
    localparam logic [12:0] A_IRQ  = 13'h0304;
    localparam logic [12:0] A_BUF  = 13'h1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [12:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ser_clk, ser_csn, ser_dout;

    int checks = 0;
    int fails  = 0;

    logic [31:0] bufm [0:7];
    logic [7:0]  dev_m;
    logic [2:0]  cnt_m;

    // memory-macro model: captures frames at rising serial clock
    logic [23:0] cap [0:7];
    int          cap_bits [0:7];
    int          ncap = 0, nbits = 0, perr = 0, gerr = 0;
    int          cyc = 0, last_rise = 0, csn_rise = 0;
    logic [23:0] sh = '0;
    logic        prev_clk = 1'b0, prev_csn = 1'b1;

    always #5 clk = ~clk;

    otp_seq u_otp_seq (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ser_clk(ser_clk), .ser_csn(ser_csn), .ser_dout(ser_dout)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (ser_clk && !prev_clk && !ser_csn) begin
                if (nbits > 0 && (cyc - last_rise) != 4) perr = perr + 1;
                last_rise = cyc;
                sh = {sh[22:0], ser_dout};
                nbits = nbits + 1;
            end
            if (!ser_csn && prev_csn && ncap > 0 && (cyc - csn_rise) != 4) gerr = gerr + 1;
            if (ser_csn && !prev_csn) begin
                csn_rise = cyc;
                if (ncap < 8) begin
                    cap[ncap] = sh;
                    cap_bits[ncap] = nbits;
                end
                ncap = ncap + 1;
                nbits = 0;
            end
        end
        prev_clk = ser_clk;
        prev_csn = ser_csn;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [12:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic int eff_of(input int c);
        return (c > 4) ? 4 : c;
    endfunction

    function automatic logic [23:0] frame_of(input logic [7:0] dv, input int k);
        return {dv, bufm[2*k][7:0], bufm[2*k+1][7:0]};
    endfunction

    task automatic load_buf(input bit directed_ecc, input logic [7:0] second);
        for (int i = 0; i < 8; i++) begin
            bufm[i] = $urandom;
            if (directed_ecc && i == 0) bufm[i] = 32'h0000_00FA;
            if (directed_ecc && i == 1) bufm[i] = {24'h0, second};
            wr(A_BUF + 13'(4 * i), bufm[i]);
        end
    endtask

    task automatic run_seq(input logic [7:0] dv, input int cnt, input bit collide, input bit poke);
        logic [31:0] r;
        int n, k, pos;
        n = eff_of(cnt);
        k = 100 * n + 2;
        wr(A_IRQ, 32'h2);
        wr(A_CNT, 32'h0007_0000 | 32'(cnt));
        dev_m = dv; cnt_m = 3'(cnt);
        ncap = 0; nbits = 0; perr = 0; gerr = 0;
        wr(A_CTRL, {8'hFF, 7'h0, 1'b1, dv, 7'h0, 1'b1});
        pos = 0;
        if (poke && k > 20) begin
            repeat (10) @(negedge clk);
            bus_wr = 1'b1; bus_addr = A_CTRL; bus_wdata = 32'hFFFF_AB00;
            @(negedge clk);
            bus_addr = A_CNT; bus_wdata = 32'hFFFF_0001;
            @(negedge clk);
            bus_addr = A_BUF; bus_wdata = 32'h0000_0055;
            @(negedge clk);
            bus_wr = 1'b0; bus_addr = A_STAT;
            #1;
            check("R5 busy while running", {31'h0, bus_rdata[0]}, 32'h1);
            pos = 13;
        end
        repeat (k - 1 - pos) @(negedge clk);
        if (collide) begin
            bus_wr = 1'b1; bus_addr = A_IRQ; bus_wdata = 32'h2;
            @(negedge clk);
            bus_wr = 1'b0;
        end else begin
            bus_addr = A_IRQ;
            #1;
            check("R5 done not yet set one cycle early", bus_rdata, 32'h0);
            @(negedge clk);
        end
        bus_addr = A_IRQ;
        #1;
        check(collide ? "R6 set wins over clear" : "R5 done on time", bus_rdata, 32'h2);
        bus_addr = A_STAT;
        #1;
        check("R5 busy cleared at finish", bus_rdata, 32'h0);
        check("R4 frame count", 32'(ncap), 32'(n));
        for (int i = 0; i < n; i++) begin
            check("R3 frame content", {8'h0, cap[i]}, {8'h0, frame_of(dv, i)});
            check("R3 frame length", 32'(cap_bits[i]), 32'd24);
        end
        check("R3 serial clock period", 32'(perr), 32'h0);
        check("R4 gap between frames", 32'(gerr), 32'h0);
        rd(A_CTRL, r);
        check(poke ? "R7 control write ignored, R5 enable self-clear" : "R5 enable self-clear",
              r, {16'h0, dv, 8'h00});
        rd(A_CNT, r);
        check("R7 count kept", r, {29'h0, 3'(cnt)});
        rd(A_BUF, r);
        check("R7 buffer kept", r, bufm[0]);
        wr(A_IRQ, 32'h0);
        rd(A_IRQ, r);
        check("R6 write of zero keeps done", r, 32'h2);
        wr(A_IRQ, 32'h2);
        rd(A_IRQ, r);
        check("R6 write of one clears done", r, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks = checks + 1;
        fails = fails + 1;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] r, d;
        logic [7:0]  dv;
        void'($urandom(32'h0000_5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R8 ser_csn after reset", {31'h0, ser_csn}, 32'h1);
        check("R8 ser_clk/ser_dout after reset", {30'h0, ser_clk, ser_dout}, 32'h0);
        rd(A_CTRL, r); check("R8 control reset", r, 32'h0);
        rd(A_STAT, r); check("R8 status reset", r, 32'h0);
        rd(A_IRQ, r);  check("R8 irq reset", r, 32'h0);

        // R1: masked writes, enable mask held off
        dev_m = 8'h00; cnt_m = 3'h0;
        for (int i = 0; i < 10; i++) begin
            d = $urandom;
            d[16] = 1'b0;
            wr(A_CTRL, d);
            dev_m = (dev_m & ~d[31:24]) | (d[15:8] & d[31:24]);
            rd(A_CTRL, r);
            check("R1 masked control write", r, {16'h0, dev_m, 8'h00});
            d = $urandom;
            wr(A_CNT, d);
            cnt_m = (cnt_m & ~d[18:16]) | (d[2:0] & d[18:16]);
            rd(A_CNT, r);
            check("R1 masked count write", r, {29'h0, cnt_m});
        end

        // R2: buffer read-back and register map
        load_buf(1'b0, 8'h00);
        for (int i = 0; i < 8; i++) begin
            rd(A_BUF + 13'(4 * i), r);
            check("R2 buffer read-back", r, bufm[i]);
        end

        // directed: error-correction off and on, zero count, clamp, collision, busy writes
        load_buf(1'b1, 8'h09);
        run_seq(8'h02, 1, 1'b0, 1'b0);
        load_buf(1'b1, 8'h00);
        run_seq(8'h02, 1, 1'b0, 1'b0);
        run_seq(8'h5A, 0, 1'b0, 1'b0);
        run_seq(8'h5A, 0, 1'b1, 1'b0);
        load_buf(1'b0, 8'h00);
        run_seq(8'hC3, 7, 1'b0, 1'b0);
        run_seq(8'h81, 2, 1'b1, 1'b0);
        run_seq(8'h3C, 3, 1'b0, 1'b1);

        // random runs
        for (int j = 0; j < 6; j++) begin
            load_buf(1'b0, 8'h00);
            dv = 8'($urandom);
            run_seq(dv, $urandom_range(0, 7), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule